// File: doc/BRIEF.md
# SPI Configuration Register File

This block is a serial slave that holds the 8-bit setup registers of a small display controller. A host drives a four-wire serial bus in mode 0 (clock idles low, data sampled on the rising edge, MSB first). Each transaction starts with a header byte. Bit 7 of the header gives the direction and bits 6..0 give the register address. A write sends one more byte, which is stored. A read gets one byte back on the slave output during the second byte slot.

All register contents are presented on one wide parallel output, so downstream display logic can use them directly. Address 0 is a fixed identification value that cannot be changed. A write to the soft-reset register with bit 0 cleared puts every writable register back to its power-on value. The serial pins are sampled with the block clock through synchronizers, so the serial clock must be several times slower than the block clock.

Top module: `spi_cfg_regfile`

## Requirements
- R1: Header bit 7 selects the direction: 0 is a write and 1 is a read. Bits 6..0 are the register address.
- R2: A write is a header byte followed by one complete data byte. The data byte is stored in the addressed register and appears on `cfg_regs[8*a +: 8]`.
- R3: For a read, the register value is loaded when the header's last bit arrives. It is driven on `spi_miso` MSB first, one bit per serial clock, valid before each rising edge of the second byte.
- R4: Address 0x00 always reads 0x96 and is not changed by writes.
- R5: Writing address 0x04 with data bit 0 equal to 0 returns every writable register to its default value in one step. Writing it with bit 0 equal to 1 simply stores the value.
- R6: Defaults are 0x0F at address 0x01, 0x2E at address 0x02 and 0x12 at address 0x03.
- R7: Defaults are 0x03 at address 0x06 (both scan-direction bits set), 0x09 at address 0x0A (clock and data-enable polarity bits 0 and 3 set, sync polarity bits 1 and 2 clear) and 0x01 at address 0x04. Every other writable address defaults to 0x00.
- R8: If chip select is raised before a byte is complete, that transaction is dropped and no register changes. The next transaction starts cleanly.
- R9: Writes to addresses above 0x44 are ignored, and reads from those addresses return 0x00.
- R10: `spi_miso_oe` is low within three clocks after chip select goes inactive and stays low while chip select is inactive. It is high while chip select is active.
- R11: The synchronous `rst` input loads all defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for the external MISO pad buffer |
| cfg_regs | output | 552 | All registers, address a at bits [8a+7:8a] |

## Verification
Reads use asymmetric values such as 0xA5 and 0x5A, so a wrong bit order or a bit-slot offset gives a different byte. Writes go to the first, last and first out-of-range addresses, which separates correct address decode from an off-by-one limit. The soft-reset register is written once with bit 0 set and once with it clear, which shows that only the clear bit triggers the reload. Transactions cut off in the header and in the data byte show that partial bytes have no effect and that the framing recovers afterwards.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    // header byte layout: direction in the MSB, address below it
    typedef struct packed {
        dir_e  dir;
        addr_t addr;
    } header_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    // power-on value of each writable register
    function automatic byte_t reg_default(input int unsigned a);
        case (a)
            1:       return 8'h0F;
            2:       return 8'h2E;
            3:       return 8'h12;
            4:       return 8'h01;
            6:       return 8'h03;
            10:      return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spicfg_frontend.sv
module spicfg_frontend
    import spicfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_pin,
    input  logic             csn_pin,
    input  logic             mosi_pin,
    output logic             link_active,
    output logic             sck_fall,
    output logic [BIT_W-1:0] bit_cnt,
    output logic             byte_done,
    output logic [1:0]       byte_idx,
    output byte_t            rx_byte
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [1:0]       IDX_SAT  = 2'd2;

    logic [SYNC_STAGES:0]   sck_q;
    logic [SYNC_STAGES-1:0] csn_q;
    logic [SYNC_STAGES-1:0] mosi_q;
    logic                   sck_rise;
    logic                   mosi_s;
    byte_t                  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SYNC_STAGES-1:0], sck_pin};
            csn_q  <= {csn_q[SYNC_STAGES-2:0], csn_pin};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_pin};
        end
    end

    assign sck_rise    = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
    assign sck_fall    = ~sck_q[SYNC_STAGES-1] & sck_q[SYNC_STAGES];
    assign link_active = ~csn_q[SYNC_STAGES-1];
    assign mosi_s      = mosi_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (!link_active) begin
                // a partial byte is dropped here
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else begin
                if (byte_done && byte_idx != IDX_SAT)
                    byte_idx <= byte_idx + 2'd1;
                if (sck_rise) begin
                    shreg   <= {shreg[BYTE_W-2:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {shreg[BYTE_W-2:0], mosi_s};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spicfg_bank.sv
module spicfg_bank
    import spicfg_pkg::*;
#(
    parameter int    MAX_ADDR   = 68,
    parameter byte_t ID_VALUE   = 8'h96,
    parameter int    RESET_ADDR = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  wr_req_t                          wr,
    input  addr_t                            rd_addr,
    output byte_t                            rd_data,
    output logic [(MAX_ADDR+1)*BYTE_W-1:0]   regs_flat
);

    localparam int    NREG  = MAX_ADDR + 1;
    localparam addr_t MAX_A = addr_t'(MAX_ADDR);
    localparam addr_t RST_A = addr_t'(RESET_ADDR);

    logic greset;
    assign greset = wr.en && (wr.addr == RST_A) && !wr.data[0];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_id
            assign regs_flat[BYTE_W-1:0] = ID_VALUE;
        end else begin : g_rw
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst || greset)
                    q <= reg_default(i);
                else if (wr.en && wr.addr == addr_t'(i))
                    q <= wr.data;
            end
            assign regs_flat[i*BYTE_W +: BYTE_W] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr <= MAX_A)
            rd_data = regs_flat[int'(rd_addr)*BYTE_W +: BYTE_W];
    end

    // R5: a clearing write to the reset register reloads defaults
    p_greset_r5: assert property (@(posedge clk) disable iff (rst)
        greset |=> regs_flat[2*BYTE_W-1:BYTE_W] == reg_default(1));

    // R9: out-of-range writes leave every register untouched
    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr > MAX_A) |=> $stable(regs_flat));

    // R2: a write to address 1 lands in that register
    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == addr_t'(1)) |=> regs_flat[2*BYTE_W-1:BYTE_W] == $past(wr.data));

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spicfg_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter int    MAX_ADDR    = 68,
    parameter byte_t ID_VALUE    = 8'h96,
    parameter int    RESET_ADDR  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           spi_sck,
    input  logic                           spi_cs_n,
    input  logic                           spi_mosi,
    output logic                           spi_miso,
    output logic                           spi_miso_oe,
    output logic [(MAX_ADDR+1)*BYTE_W-1:0] cfg_regs
);

    logic             active;
    logic             fall;
    logic [BIT_W-1:0] bit_cnt;
    logic             byte_done;
    logic [1:0]       byte_idx;
    byte_t            rx_byte;
    byte_t            rd_data;
    header_t          hdr_now;
    header_t          hdr_q;
    byte_t            tx_sh;
    wr_req_t          wr;

    spicfg_frontend #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk         (clk),
        .rst         (rst),
        .sck_pin     (spi_sck),
        .csn_pin     (spi_cs_n),
        .mosi_pin    (spi_mosi),
        .link_active (active),
        .sck_fall    (fall),
        .bit_cnt     (bit_cnt),
        .byte_done   (byte_done),
        .byte_idx    (byte_idx),
        .rx_byte     (rx_byte)
    );

    assign hdr_now = header_t'(rx_byte);

    // header latch and read shifter
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
            tx_sh <= '0;
        end else if (!active) begin
            tx_sh <= '0;
        end else if (byte_done && byte_idx == 2'd0) begin
            hdr_q <= hdr_now;
            tx_sh <= (hdr_now.dir == DIR_READ) ? rd_data : '0;
        end else if (fall && bit_cnt != '0) begin
            // the edge that closes a byte does not shift
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    always_comb begin
        wr.en   = byte_done && (byte_idx == 2'd1) && (hdr_q.dir == DIR_WRITE);
        wr.addr = hdr_q.addr;
        wr.data = rx_byte;
    end

    spicfg_bank #(
        .MAX_ADDR   (MAX_ADDR),
        .ID_VALUE   (ID_VALUE),
        .RESET_ADDR (RESET_ADDR)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_addr   (hdr_now.addr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

    assign spi_miso    = tx_sh[BYTE_W-1];
    assign spi_miso_oe = active;

    // R10: a chip select held high keeps the pad buffer off
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

    // R3: the byte-closing falling edge holds the first read bit
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(fall) && $past(bit_cnt) == '0 && !$past(byte_done) && active && $past(active))
        |-> spi_miso == $past(spi_miso));

endmodule

// File: tb/sim_spi_cfg_regfile.sv
module sim_spi_cfg_regfile;

    localparam int NREG = 69;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;
    logic [NREG*8-1:0] cfg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int hi_cnt   = 0;
    int lo_cnt   = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    spi_cfg_regfile u0 (
        .clk         (clk),
        .rst         (rst),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .cfg_regs    (cfg)
    );

    task automatic model_defaults();
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        model[0]  = 8'h96;
        model[1]  = 8'h0F;
        model[2]  = 8'h2E;
        model[3]  = 8'h12;
        model[4]  = 8'h01;
        model[6]  = 8'h03;
        model[10] = 8'h09;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst) begin
            hi_cnt = 0;
            lo_cnt = 0;
        end else begin
            if (cs_n) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; end
            if (hi_cnt >= 4) begin
                n_checks++;
                if (miso_oe !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R10: oe actual %b expected 0", miso_oe);
                end
            end
            if (lo_cnt >= 4) begin
                n_checks++;
                if (miso_oe !== 1'b1) begin
                    n_fail++;
                    $display("FAIL R10: oe actual %b expected 1", miso_oe);
                end
            end
            if (hi_cnt >= 16) begin
                automatic int bad = -1;
                n_checks++;
                for (int a = NREG - 1; a >= 0; a--)
                    if (cfg[a*8 +: 8] !== model[a]) bad = a;
                if (bad >= 0) begin
                    n_fail++;
                    $display("FAIL R2: cfg[%0d] actual %02h expected %02h",
                             bad, cfg[bad*8 +: 8], model[bad]);
                end
            end
        end
    end

    task automatic send_bit(input logic b, output logic s);
        mosi = b;
        repeat (H) @(negedge clk);
        s = miso;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame(input logic [7:0] hdr, input int hbits,
                         input logic [7:0] dat, input int dbits,
                         output logic [7:0] rd);
        logic s;
        rd = 8'h00;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < hbits; i++) send_bit(hdr[7-i], s);
        for (int j = 0; j < dbits; j++) begin
            send_bit(dat[7-j], s);
            rd[7-j] = s;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] r;
        frame({1'b0, a}, 8, d, 8, r);
        if (a != 0 && a <= 7'h44) begin
            if (a == 7'h04 && !d[0]) model_defaults();
            else model[a] = d;
        end
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] v);
        frame({1'b1, a}, 8, 8'h00, 8, v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        model_defaults();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        idle(20);

        // R11 reset state at the port, R7 untouched address
        chk("R11 cfg[1]", cfg[15:8], 8'h0F);
        chk("R7 cfg[5]", cfg[47:40], 8'h00);
        chk("R10 oe idle", {7'd0, miso_oe}, 8'h00);

        // R6 / R7 defaults read through the bus (R1 read direction)
        do_read(7'h01, v); chk("R6 addr01", v, 8'h0F);
        do_read(7'h02, v); chk("R6 addr02", v, 8'h2E);
        do_read(7'h03, v); chk("R6 addr03", v, 8'h12);
        do_read(7'h06, v); chk("R7 addr06", v, 8'h03);
        do_read(7'h0A, v); chk("R7 addr0A", v, 8'h09);
        do_read(7'h04, v); chk("R7 addr04", v, 8'h01);

        // R4 identification
        do_read(7'h00, v); chk("R4 id", v, 8'h96);

        // R2 / R3 write then read back, asymmetric bit patterns
        do_write(7'h10, 8'hA5); idle(20);
        do_read(7'h10, v); chk("R3 addr10", v, 8'hA5);
        chk("R2 cfg[16]", cfg[16*8 +: 8], 8'hA5);
        do_write(7'h44, 8'h5A); idle(20);
        do_read(7'h44, v); chk("R3 addr44", v, 8'h5A);
        do_write(7'h01, 8'h3C); idle(20);
        chk("R2 cfg[1]", cfg[15:8], 8'h3C);

        // R1: a read header must not write
        frame({1'b1, 7'h01}, 8, 8'hFF, 8, v);
        chk("R1 read no write", v, 8'h3C);
        idle(20);
        chk("R1 cfg[1] kept", cfg[15:8], 8'h3C);

        // R4 write to the ID register ignored
        do_write(7'h00, 8'h12); idle(20);
        do_read(7'h00, v); chk("R4 id after write", v, 8'h96);

        // R9 out of range
        do_write(7'h45, 8'hFF); idle(20);
        do_write(7'h7F, 8'hEE); idle(20);
        do_read(7'h45, v); chk("R9 read 45", v, 8'h00);
        do_read(7'h7F, v); chk("R9 read 7F", v, 8'h00);
        chk("R9 cfg[68] kept", cfg[68*8 +: 8], 8'h5A);

        // R8 aborts in the data byte and in the header
        frame({1'b0, 7'h10}, 8, 8'h00, 4, v); idle(20);
        chk("R8 data abort", cfg[16*8 +: 8], 8'hA5);
        frame({1'b0, 7'h02}, 5, 8'h00, 0, v); idle(20);
        do_read(7'h02, v); chk("R8 recover", v, 8'h2E);

        // R5 soft reset: bit0 set stores, bit0 clear reloads
        do_write(7'h04, 8'h81); idle(20);
        chk("R5 store 81", cfg[4*8 +: 8], 8'h81);
        chk("R5 no reload", cfg[16*8 +: 8], 8'hA5);
        do_write(7'h04, 8'h00); idle(20);
        chk("R5 reload 10", cfg[16*8 +: 8], 8'h00);
        chk("R5 reload 01", cfg[15:8], 8'h0F);
        chk("R5 reload 04", cfg[4*8 +: 8], 8'h01);
        chk("R5 reload 44", cfg[68*8 +: 8], 8'h00);

        // R11 pin reset
        do_write(7'h0A, 8'hF0); idle(20);
        chk("R2 cfg[10]", cfg[10*8 +: 8], 8'hF0);
        rst = 1'b1;
        model_defaults();
        idle(3);
        rst = 1'b0;
        idle(20);
        chk("R11 cfg[10]", cfg[10*8 +: 8], 8'h09);
        do_read(7'h0A, v); chk("R11 read 0A", v, 8'h09);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule